// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

A bank of general-purpose pins with its own register file on a plain word-addressed bus with a write strobe and a read strobe. Each pin is a general input, a general output, or an interrupt input. The pad inputs pass through a two-stage synchronizer before any logic sees them. The block drives each output pad and its enable straight from the register state.

Interrupt pins sense a level or an edge. The polarity can be inverted, and edge pins can fire on both edges. Edge events latch into sticky pending bits, which software clears by writing ones. The enable mask has two write paths: one address sets bits and another keeps only the bits written as one. All enabled status bits are ORed into a single request line. Reads are combinational while the read strobe is high and return zero when it is low.

Top module: `gpio_bank`

## Requirements
- R1: After reset every register reads 0, no pad is driven and irq_o is low.
- R2: pad_oe_o bit n is 1 only when mode bit n is 0 (offset 0x00), direction bit n is 1 (offset 0x04) and source-select bit n is 0 (offset 0x40). pad_o carries the output latch (offset 0x08).
- R3: A read of offset 0x0C returns the output latch for output pins and the pad value for input pins, synchronized through two flops.
- R4: A level pin (mode 1, offset 0x24 bit 0) shows status (offset 0x10) equal to pad XOR polarity (offset 0x20, 1 = active low). Writes to the clear register leave that status unchanged.
- R5: An edge pin (offset 0x24 bit 1) latches a sticky pending bit on a rising edge when polarity is 0 and on a falling edge when polarity is 1. The opposite edge has no effect.
- R6: With the both-edge bit (offset 0x4C) set, an edge pin latches on either edge, whatever its polarity.
- R7: Writing 1 to bit n of offset 0x14 clears pending bit n. Writing 0 leaves it set.
- R8: A clear and a new edge on the same pin in the same cycle leave the pending bit set.
- R9: Writing ones to offset 0x1C sets those enable bits. A write to offset 0x18 clears every enable bit written as 0 and keeps the rest. Offset 0x18 reads back the enables.
- R10: irq_o is high exactly when some status bit and its enable bit are both 1.
- R11: A write that moves a pin from general I/O into interrupt mode clears its pending bit. A pin in general I/O mode shows status 0.
- R12: Unused offsets and the write-only offsets 0x14 and 0x1C read 0. The configuration registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address, word aligned |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | NPINS | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | NPINS | Read data, zero when rd_i is low |
| pad_i | input | NPINS | Pad inputs, asynchronous |
| pad_o | output | NPINS | Pad output values |
| pad_oe_o | output | NPINS | Pad output enables |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench times a clear write so that it lands in the same cycle as a fresh edge on the same pin. A design in which the clear takes priority would drop that event. It moves a pin out of interrupt mode and back while a pending bit is held, to catch a design that keeps stale pending state or reports status in I/O mode. It sends the wrong edge for each polarity and writes zeros to the clear register, to catch detectors that are too eager and clears that are not write-one-to-clear. It also writes all ones and then zeros to the mask register, which exposes a mask treated as a plain store instead of a keep-ones write.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFS_MODE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DOUT  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_DIN   = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_UNMSK = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_EDGE  = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_OSEL  = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 8'h4C;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] st_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
      prev_q <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
      prev_q <= st_q[STAGES-1];
    end
  end

  assign cur_o  = st_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_irq_cell.sv
module gpio_irq_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cur_i,
  input  logic prev_i,
  input  logic intr_i,
  input  logic edg_i,
  input  logic pol_i,
  input  logic both_i,
  input  logic clr_i,
  output logic stat_o
);
  logic pend_q, ev, hit;

  always_comb begin
    if (both_i)     hit = cur_i ^ prev_i;
    else if (pol_i) hit = prev_i & ~cur_i;
    else            hit = cur_i & ~prev_i;
  end
  assign ev = intr_i & edg_i & hit;

  // new event beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q & ~clr_i) | ev;
  end

  assign stat_o = intr_i & (edg_i ? pend_q : (cur_i ^ pol_i));

  a_r8_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev |=> pend_q);
  a_r7_clear_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !ev) |=> !pend_q);
  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !clr_i) |=> pend_q);
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic              rd_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] mode_q, dir_q, dout_q, mask_q, pol_q, edge_q, osel_q, both_q;
  logic [NPINS-1:0] cur, prev, stat, clr, din;

  gpio_sync #(.W(NPINS), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_i),
    .cur_o (cur),
    .prev_o(prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0; dir_q <= '0; dout_q <= '0; mask_q <= '0;
      pol_q  <= '0; edge_q <= '0; osel_q <= '0; both_q <= '0;
    end else if (wr_i) begin
      case (addr_i)
        OFS_MODE:  mode_q <= wdata_i;
        OFS_DIR:   dir_q  <= wdata_i;
        OFS_DOUT:  dout_q <= wdata_i;
        OFS_MASK:  mask_q <= mask_q & wdata_i;
        OFS_UNMSK: mask_q <= mask_q | wdata_i;
        OFS_POL:   pol_q  <= wdata_i;
        OFS_EDGE:  edge_q <= wdata_i;
        OFS_OSEL:  osel_q <= wdata_i;
        OFS_BOTH:  both_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // clear on W1C write or on entry into interrupt mode
  always_comb begin
    clr = '0;
    if (wr_i && addr_i == OFS_CLR)  clr = wdata_i;
    if (wr_i && addr_i == OFS_MODE) clr = clr | (wdata_i & ~mode_q);
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpio_irq_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cur_i (cur[i]),
      .prev_i(prev[i]),
      .intr_i(mode_q[i]),
      .edg_i (edge_q[i]),
      .pol_i (pol_q[i]),
      .both_i(both_q[i]),
      .clr_i (clr[i]),
      .stat_o(stat[i])
    );
  end

  assign din      = (dir_q & dout_q) | (~dir_q & cur);
  assign pad_o    = dout_q;
  assign pad_oe_o = ~mode_q & dir_q & ~osel_q;
  assign irq_o    = |(stat & mask_q);

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      case (addr_i)
        OFS_MODE: rdata_o = mode_q;
        OFS_DIR:  rdata_o = dir_q;
        OFS_DOUT: rdata_o = dout_q;
        OFS_DIN:  rdata_o = din;
        OFS_STAT: rdata_o = stat;
        OFS_MASK: rdata_o = mask_q;
        OFS_POL:  rdata_o = pol_q;
        OFS_EDGE: rdata_o = edge_q;
        OFS_OSEL: rdata_o = osel_q;
        OFS_BOTH: rdata_o = both_q;
        default:  rdata_o = '0;
      endcase
    end
  end

  a_r9_mask_keeps_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_MASK) |=> ((mask_q & ~$past(wdata_i)) == '0));
  a_r9_unmask_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == OFS_UNMSK) |=> ((~mask_q & $past(wdata_i)) == '0));
  a_r10_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (mask_q != '0));
endmodule

// File: tb/gpio_bank_bench.sv
module gpio_bank_bench;
  localparam int N = 56;
  // row: {kind[2:0], req[3:0], addr[7:0], data[31:0]}
  // kind 0 write, 1 read check, 2 pad set + settle, 3 irq check, 4 oe check
  localparam logic [46:0] VEC [N] = '{
    {3'd0,4'd2,8'h04,32'h0000000F}, {3'd0,4'd2,8'h08,32'h00000005},
    {3'd4,4'd2,8'h00,32'h0000000F}, {3'd1,4'd3,8'h0C,32'h00000005}, // R2 R3
    {3'd0,4'd2,8'h40,32'h00000002}, {3'd4,4'd2,8'h00,32'h0000000D},
    {3'd0,4'd2,8'h00,32'h00000001}, {3'd4,4'd2,8'h00,32'h0000000C},
    {3'd0,4'd3,8'h04,32'h00000000}, {3'd0,4'd3,8'h00,32'h00000000},
    {3'd0,4'd3,8'h40,32'h00000000}, {3'd2,4'd3,8'h00,32'hA5A50000},
    {3'd1,4'd3,8'h0C,32'hA5A50000}, {3'd2,4'd4,8'h00,32'h00000000},
    {3'd0,4'd4,8'h00,32'h00000001}, {3'd1,4'd4,8'h10,32'h00000000}, // R4 level
    {3'd2,4'd4,8'h00,32'h00000001}, {3'd1,4'd4,8'h10,32'h00000001},
    {3'd0,4'd4,8'h14,32'h00000001}, {3'd1,4'd4,8'h10,32'h00000001},
    {3'd0,4'd4,8'h20,32'h00000001}, {3'd1,4'd4,8'h10,32'h00000000},
    {3'd2,4'd4,8'h00,32'h00000000}, {3'd1,4'd4,8'h10,32'h00000001},
    {3'd0,4'd10,8'h1C,32'h00000001}, {3'd3,4'd10,8'h00,32'h00000001}, // R10
    {3'd2,4'd4,8'h00,32'h00000001}, {3'd1,4'd4,8'h10,32'h00000000},
    {3'd3,4'd10,8'h00,32'h00000000}, {3'd0,4'd5,8'h20,32'h00000000},
    {3'd0,4'd5,8'h24,32'h00000001}, {3'd1,4'd5,8'h10,32'h00000000}, // R5 rising
    {3'd2,4'd5,8'h00,32'h00000000}, {3'd1,4'd5,8'h10,32'h00000000},
    {3'd2,4'd5,8'h00,32'h00000001}, {3'd1,4'd5,8'h10,32'h00000001},
    {3'd2,4'd5,8'h00,32'h00000000}, {3'd1,4'd5,8'h10,32'h00000001},
    {3'd0,4'd7,8'h14,32'h00000000}, {3'd1,4'd7,8'h10,32'h00000001}, // R7
    {3'd0,4'd7,8'h14,32'h00000001}, {3'd1,4'd7,8'h10,32'h00000000},
    {3'd0,4'd5,8'h20,32'h00000001}, {3'd2,4'd5,8'h00,32'h00000001}, // R5 falling
    {3'd1,4'd5,8'h10,32'h00000000}, {3'd2,4'd5,8'h00,32'h00000000},
    {3'd1,4'd5,8'h10,32'h00000001}, {3'd0,4'd5,8'h14,32'h00000001},
    {3'd0,4'd6,8'h4C,32'h00000001}, {3'd2,4'd6,8'h00,32'h00000001}, // R6
    {3'd1,4'd6,8'h10,32'h00000001}, {3'd0,4'd6,8'h14,32'h00000001},
    {3'd2,4'd6,8'h00,32'h00000000}, {3'd1,4'd6,8'h10,32'h00000001},
    {3'd0,4'd6,8'h14,32'h00000001}, {3'd1,4'd6,8'h10,32'h00000000}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        wr_i = 1'b0, rd_i = 1'b0;
  logic [31:0] wdata_i = '0, pad_i = '0;
  logic [31:0] rdata_o, pad_o, pad_oe_o;
  logic        irq_o;
  int total = 0, bad = 0;

  always #5 clk_i = ~clk_i;

  gpio_bank u_gpio_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .rd_i(rd_i), .rdata_o(rdata_o), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe_o(pad_oe_o), .irq_o(irq_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i); wr_i = 1'b0;
  endtask

  task automatic bus_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk_i); addr_i = a; rd_i = 1'b1;
    #1 check(req, rdata_o, exp);
    rd_i = 1'b0;
  endtask

  task automatic pad_set(input logic [31:0] v);
    @(negedge clk_i); pad_i = v;
    repeat (4) @(posedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    for (int i = 0; i < 20; i++) bus_rd("R1", 8'(i * 4), 32'h0);
    check("R1", pad_oe_o, 32'h0);
    check("R1", {31'h0, irq_o}, 32'h0);

    for (int i = 0; i < N; i++) begin
      automatic logic [2:0]  k = VEC[i][46:44];
      automatic string       rq = $sformatf("R%0d", VEC[i][43:40]);
      automatic logic [7:0]  a = VEC[i][39:32];
      automatic logic [31:0] d = VEC[i][31:0];
      case (k)
        3'd0: bus_wr(a, d);
        3'd1: bus_rd(rq, a, d);
        3'd2: pad_set(d);
        3'd3: begin @(negedge clk_i); check(rq, {31'h0, irq_o}, d); end
        default: begin @(negedge clk_i); check(rq, pad_oe_o, d); end
      endcase
    end

    // R9 mask paths
    bus_wr(8'h1C, 32'h6);          bus_rd("R9", 8'h18, 32'h7);
    bus_wr(8'h18, 32'hFFFFFFFD);   bus_rd("R9", 8'h18, 32'h5);
    bus_wr(8'h18, 32'hFFFFFFFF);   bus_rd("R9", 8'h18, 32'h5);
    bus_wr(8'h18, 32'h0);          bus_rd("R9", 8'h18, 32'h0);
    @(negedge clk_i); check("R10", {31'h0, irq_o}, 32'h0);

    // R11 re-entry into interrupt mode drops pending
    pad_set(32'h1);                bus_rd("R11", 8'h10, 32'h1);
    bus_wr(8'h00, 32'h0);          bus_rd("R11", 8'h10, 32'h0);
    bus_wr(8'h00, 32'h1);          bus_rd("R11", 8'h10, 32'h0);

    // R8 clear lands in the cycle of a new edge
    pad_set(32'h0);                bus_rd("R8", 8'h10, 32'h1);
    @(negedge clk_i); pad_i = 32'h1;
    @(posedge clk_i); @(negedge clk_i);
    @(posedge clk_i); @(negedge clk_i);
    addr_i = 8'h14; wdata_i = 32'h1; wr_i = 1'b1;
    @(posedge clk_i); @(negedge clk_i); wr_i = 1'b0;
    bus_rd("R8", 8'h10, 32'h1);
    bus_wr(8'h14, 32'h1);          bus_rd("R7", 8'h10, 32'h0);

    // R12 read map
    bus_rd("R12", 8'h2C, 32'h0);
    bus_rd("R12", 8'h14, 32'h0);
    bus_rd("R12", 8'h1C, 32'h0);
    bus_rd("R12", 8'h00, 32'h1);
    bus_rd("R12", 8'h4C, 32'h1);
    bus_rd("R12", 8'h24, 32'h1);
    bus_rd("R12", 8'h20, 32'h1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule